// File: doc/BRIEF.md
# Multi-Set Triggered Logic Analyzer

This block is an on-chip capture engine. Several equal-width groups of design signals (signal sets) arrive on one flat input bus. One set, the capture set, is written into an internal sample RAM on every clock while the analyzer records. A second set, the trigger set, is selected on its own and can be the same set or a different one. It feeds a masked pattern comparator. An external hardware trigger pin can take the comparator's place.

The RAM is a circular buffer. After an arm command the engine records continuously and waits for a trigger for as long as it takes. A trigger counts only once a programmable number of pre-trigger samples have been stored. After the trigger the engine fills the rest of the buffer and stops in a done state. It keeps the address of the trigger sample, so a host can find both the oldest sample and the trigger point. A host drives the block through a small register write port. It reads the state, the trigger address and any stored sample through direct outputs and a read address port.

Top module: `mset_logic_analyzer`

## Requirements
- R1: After reset the state output is IDLE (code 0), done_o is 0, trig_addr_o is 0 and rd_data_o is 0. Pattern, mask, selections and pre-trigger count all reset to 0.
- R2: Register 2 bits [3:0] select the capture set. Set k occupies sets_i bits [k*SET_W +: SET_W]. An index at or above NUM_SETS selects set 0.
- R3: With register 2 bit 8 clear, the trigger condition is (trigger set & mask) == (pattern & mask). Register 0 holds the pattern and register 1 the mask, both in the low SET_W bits. The trigger fires only on a cycle where the condition is true and was false on the previous cycle.
- R4: With register 2 bit 8 set, the trigger condition is ext_trig_i and fires on its rising edge. Pattern matches then have no effect.
- R5: Register 2 bits [7:4] select the trigger set independently of the capture set, with the same out-of-range rule as R2.
- R6: Command register 4 bit 0 (arm) in IDLE or DONE moves the state to ARMED (code 1) on the next cycle. From then on, one capture-set sample is written per clock in ARMED and CAPTURING (code 2). The first sample goes to address 0 and the address wraps modulo DEPTH.
- R7: With pre-trigger count P (register 3, low ADDR_W bits), a trigger is accepted only from sample index P onward, counting from 0 after arming. The trigger sample's address is latched on trig_addr_o. Exactly DEPTH-1-P further samples are stored, and then the state becomes DONE (code 3). If P is DEPTH-1, the state goes straight to DONE.
- R8: In ARMED with no trigger event, the analyzer stays ARMED indefinitely.
- R9: DONE holds, with done_o high and no RAM writes, until a command write. Command bit 1 (clear) returns any state to IDLE and has priority over arm. Arm from DONE re-arms directly.
- R10: A write to registers 0 to 3 while ARMED or CAPTURING aborts to IDLE on the next cycle. A command write with neither bit set does not abort.
- R11: rd_data_o shows the RAM word at rd_addr_i one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sets_i | input | NUM_SETS*SET_W | All signal sets, set k in slice k |
| ext_trig_i | input | 1 | External hardware trigger |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register index (0 pattern, 1 mask, 2 select, 3 pre-trigger, 4 command) |
| cfg_wdata_i | input | REG_W | Register write data |
| rd_addr_i | input | ADDR_W | Sample RAM read address |
| rd_data_o | output | SET_W | Sample RAM read data, one cycle latency |
| state_o | output | 2 | 0 IDLE, 1 ARMED, 2 CAPTURING, 3 DONE |
| done_o | output | 1 | High while in DONE |
| trig_addr_o | output | ADDR_W | RAM address of the trigger sample |

## Verification
The assertions check the control sequencing on every cycle: arm, clear and abort reach their target state one clock later, DONE and IDLE hold without commands, an ARMED engine with an external source and a low pin never leaves ARMED, and the trigger address stays frozen while capturing. The trigger instant, the pre-trigger qualification and the contents of the circular buffer can only be shown by the bench's scenarios. These sweep every capture set against a different trigger set over several pre-trigger counts, using both trigger sources. The bench reads back every buffer word against values it computes from the known input sequence.

// File: rtl/mset_la_pkg.sv
package mset_la_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT = 2'd2,
    ST_DONE = 2'd3
  } la_state_e;

  localparam logic [2:0] REG_PAT = 3'd0;
  localparam logic [2:0] REG_MASK = 3'd1;
  localparam logic [2:0] REG_SEL = 3'd2;
  localparam logic [2:0] REG_PRE = 3'd3;
  localparam logic [2:0] REG_CMD = 3'd4;

  localparam int SEL_IDX_W = 4;
  localparam int SEL_CAP_LSB = 0;
  localparam int SEL_TRG_LSB = 4;
  localparam int SEL_EXT_BIT = 8;
  localparam int CMD_ARM_BIT = 0;
  localparam int CMD_CLR_BIT = 1;

endpackage

// File: rtl/mset_la_set_mux.sv
module mset_la_set_mux #(
  parameter int NUM_SETS = 4,
  parameter int SET_W = 8,
  parameter int IDX_W = 4
) (
  input  logic [NUM_SETS*SET_W-1:0] sets_i,
  input  logic [IDX_W-1:0]          idx_i,
  output logic [SET_W-1:0]          set_o
);

  logic [SET_W-1:0] slice [NUM_SETS];

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_slice
    assign slice[g] = sets_i[g*SET_W +: SET_W];
  end

  always_comb begin
    set_o = slice[0];
    for (int i = 1; i < NUM_SETS; i++) begin
      if (idx_i == IDX_W'(i)) begin
        set_o = slice[i];
      end
    end
  end

endmodule

// File: rtl/mset_la_trig.sv
module mset_la_trig #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] value_i,
  input  logic [SET_W-1:0] pattern_i,
  input  logic [SET_W-1:0] mask_i,
  input  logic             use_ext_i,
  input  logic             ext_i,
  output logic             fire_o
);

  logic cond;
  logic cond_q;

  always_comb begin
    if (use_ext_i) begin
      cond = ext_i;
    end else begin
      cond = ((value_i & mask_i) == (pattern_i & mask_i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
    end else begin
      cond_q <= cond;
    end
  end

  assign fire_o = cond & ~cond_q;

endmodule

// File: rtl/mset_la_ram.sv
module mset_la_ram #(
  parameter int DEPTH = 1024,
  parameter int SET_W = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [SET_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [SET_W-1:0]  rdata_o
);

  logic [SET_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= mem[raddr_i];
    end
  end

endmodule

// File: rtl/mset_la_ctrl.sv
module mset_la_ctrl
  import mset_la_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              clr_i,
  input  logic              abort_i,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] pre_i,
  output la_state_e         state_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] trig_addr_o
);

  la_state_e         state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] fill_q, fill_d;
  logic [ADDR_W-1:0] remain_q, remain_d;
  logic [ADDR_W-1:0] taddr_q, taddr_d;
  logic              recording;
  logic              qualified;
  logic              take_trig;
  logic              do_arm;
  logic [ADDR_W-1:0] post_cnt;

  assign recording = (state_q == ST_ARMED) || (state_q == ST_CAPT);
  assign qualified = (fill_q == pre_i);
  assign post_cnt  = ~pre_i;
  assign do_arm    = arm_i && !clr_i &&
                     ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign take_trig = (state_q == ST_ARMED) && fire_i && qualified &&
                     !abort_i && !clr_i;
  assign we_o      = recording && !abort_i && !clr_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (do_arm) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (take_trig) begin
          state_d = (post_cnt == '0) ? ST_DONE : ST_CAPT;
        end
      end
      ST_CAPT: begin
        if (remain_q == ADDR_W'(1)) state_d = ST_DONE;
      end
      ST_DONE: begin
        if (do_arm) state_d = ST_ARMED;
      end
      default: state_d = ST_IDLE;
    endcase
    if (clr_i || (abort_i && recording)) begin
      state_d = ST_IDLE;
    end
  end

  always_comb begin
    ptr_d    = ptr_q;
    fill_d   = fill_q;
    remain_d = remain_q;
    taddr_d  = taddr_q;
    if (do_arm) begin
      ptr_d  = '0;
      fill_d = '0;
    end else if (we_o) begin
      ptr_d = ptr_q + ADDR_W'(1);
      if ((state_q == ST_ARMED) && !qualified) begin
        fill_d = fill_q + ADDR_W'(1);
      end
      if (state_q == ST_CAPT) begin
        remain_d = remain_q - ADDR_W'(1);
      end
    end
    if (take_trig) begin
      taddr_d  = ptr_q;
      remain_d = post_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      fill_q   <= '0;
      remain_q <= '0;
      taddr_q  <= '0;
    end else begin
      state_q  <= state_d;
      ptr_q    <= ptr_d;
      fill_q   <= fill_d;
      remain_q <= remain_d;
      taddr_q  <= taddr_d;
    end
  end

  assign state_o     = state_q;
  assign waddr_o     = ptr_q;
  assign trig_addr_o = taddr_q;

endmodule

// File: rtl/mset_logic_analyzer.sv
module mset_logic_analyzer
  import mset_la_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int SET_W = 8,
  parameter int DEPTH = 1024,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int REG_W = (SET_W > 16) ? SET_W : 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SETS*SET_W-1:0] sets_i,
  input  logic                      ext_trig_i,
  input  logic                      cfg_we_i,
  input  logic [2:0]                cfg_addr_i,
  input  logic [REG_W-1:0]          cfg_wdata_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [SET_W-1:0]          rd_data_o,
  output logic [1:0]                state_o,
  output logic                      done_o,
  output logic [ADDR_W-1:0]         trig_addr_o
);

  logic [SET_W-1:0]     pattern_q;
  logic [SET_W-1:0]     mask_q;
  logic [SEL_IDX_W-1:0] cap_sel_q;
  logic [SEL_IDX_W-1:0] trg_sel_q;
  logic                 use_ext_q;
  logic [ADDR_W-1:0]    pre_q;
  logic                 en_pat, en_mask, en_sel, en_pre;
  logic                 cmd_arm, cmd_clr, cfg_hit;
  logic [SET_W-1:0]     cap_val, trg_val;
  logic                 fire;
  logic                 ram_we;
  logic [ADDR_W-1:0]    ram_waddr;
  la_state_e            state;
  logic                 unused_wdata;

  assign unused_wdata = ^cfg_wdata_i[REG_W-1:SEL_EXT_BIT+1];

  assign en_pat  = cfg_we_i && (cfg_addr_i == REG_PAT);
  assign en_mask = cfg_we_i && (cfg_addr_i == REG_MASK);
  assign en_sel  = cfg_we_i && (cfg_addr_i == REG_SEL);
  assign en_pre  = cfg_we_i && (cfg_addr_i == REG_PRE);
  assign cfg_hit = en_pat || en_mask || en_sel || en_pre;
  assign cmd_arm = cfg_we_i && (cfg_addr_i == REG_CMD) && cfg_wdata_i[CMD_ARM_BIT];
  assign cmd_clr = cfg_we_i && (cfg_addr_i == REG_CMD) && cfg_wdata_i[CMD_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pattern_q <= '0;
      mask_q    <= '0;
      cap_sel_q <= '0;
      trg_sel_q <= '0;
      use_ext_q <= 1'b0;
      pre_q     <= '0;
    end else begin
      if (en_pat)  pattern_q <= cfg_wdata_i[SET_W-1:0];
      if (en_mask) mask_q    <= cfg_wdata_i[SET_W-1:0];
      if (en_sel) begin
        cap_sel_q <= cfg_wdata_i[SEL_CAP_LSB +: SEL_IDX_W];
        trg_sel_q <= cfg_wdata_i[SEL_TRG_LSB +: SEL_IDX_W];
        use_ext_q <= cfg_wdata_i[SEL_EXT_BIT];
      end
      if (en_pre)  pre_q     <= cfg_wdata_i[ADDR_W-1:0];
    end
  end

  mset_la_set_mux #(.NUM_SETS(NUM_SETS), .SET_W(SET_W), .IDX_W(SEL_IDX_W)) i_cap_mux (
    .sets_i(sets_i), .idx_i(cap_sel_q), .set_o(cap_val)
  );

  mset_la_set_mux #(.NUM_SETS(NUM_SETS), .SET_W(SET_W), .IDX_W(SEL_IDX_W)) i_trg_mux (
    .sets_i(sets_i), .idx_i(trg_sel_q), .set_o(trg_val)
  );

  mset_la_trig #(.SET_W(SET_W)) i_trig (
    .clk(clk), .rst_n(rst_n), .value_i(trg_val), .pattern_i(pattern_q),
    .mask_i(mask_q), .use_ext_i(use_ext_q), .ext_i(ext_trig_i), .fire_o(fire)
  );

  mset_la_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_i(cmd_arm), .clr_i(cmd_clr),
    .abort_i(cfg_hit), .fire_i(fire), .pre_i(pre_q), .state_o(state),
    .we_o(ram_we), .waddr_o(ram_waddr), .trig_addr_o(trig_addr_o)
  );

  mset_la_ram #(.DEPTH(DEPTH), .SET_W(SET_W), .ADDR_W(ADDR_W)) i_ram (
    .clk(clk), .rst_n(rst_n), .we_i(ram_we), .waddr_i(ram_waddr),
    .wdata_i(cap_val), .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  assign state_o = state;
  assign done_o  = (state == ST_DONE);

endmodule

// File: rtl/mset_la_checker.sv
module mset_la_checker #(
  parameter int REG_W = 16,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we_i,
  input logic [2:0]        cfg_addr_i,
  input logic [REG_W-1:0]  cfg_wdata_i,
  input logic              ext_trig_i,
  input logic              use_ext,
  input logic [1:0]        state_o,
  input logic [ADDR_W-1:0] trig_addr_o
);

  logic cmd_wr;
  assign cmd_wr = cfg_we_i && (cfg_addr_i == 3'd4);

  AST_ARM_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cfg_wdata_i[0] && !cfg_wdata_i[1] && (state_o == 2'd0 || state_o == 2'd3))
    |=> (state_o == 2'd1)); // R6

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cfg_wdata_i[1]) |=> (state_o == 2'd0)); // R9

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && !cmd_wr) |=> (state_o == 2'd3)); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && !(cmd_wr && cfg_wdata_i[0])) |=> (state_o == 2'd0)); // R9

  AST_CFG_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && !cfg_addr_i[2] && (state_o == 2'd1 || state_o == 2'd2))
    |=> (state_o == 2'd0)); // R10

  AST_EXT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && !cfg_we_i && use_ext && !ext_trig_i) |=> (state_o == 2'd1)); // R8

  AST_TADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |=> $stable(trig_addr_o)); // R7

endmodule

bind mset_logic_analyzer mset_la_checker #(.REG_W(REG_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
  .cfg_wdata_i(cfg_wdata_i), .ext_trig_i(ext_trig_i), .use_ext(use_ext_q),
  .state_o(state_o), .trig_addr_o(trig_addr_o)
);

// File: tb/test_mset_logic_analyzer.sv
`timescale 1ns/100ps
module test_mset_logic_analyzer;

  localparam int NS = 4;
  localparam int SW = 8;
  localparam int DP = 16;
  localparam int AW = 4;
  localparam int RW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS*SW-1:0] sets;
  logic          ext_trig;
  logic          cfg_we;
  logic [2:0]    cfg_addr;
  logic [RW-1:0] cfg_wdata;
  logic [AW-1:0] rd_addr;
  logic [SW-1:0] rd_data;
  logic [1:0]    state;
  logic          done;
  logic [AW-1:0] trig_addr;

  int n_checks = 0;
  int n_fail = 0;
  int ncyc = 0;
  int wd = 0;
  int n0;

  always #2.5 clk = ~clk;

  mset_logic_analyzer #(.NUM_SETS(NS), .SET_W(SW), .DEPTH(DP)) i_mset_logic_analyzer (
    .clk(clk), .rst_n(rst_n), .sets_i(sets), .ext_trig_i(ext_trig),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .state_o(state),
    .done_o(done), .trig_addr_o(trig_addr)
  );

  function automatic logic [SW-1:0] fval(input int s, input int n);
    return SW'((n + 40 * s) & 255);
  endfunction

  always @(negedge clk) ncyc <= ncyc + 1;

  always_comb begin
    for (int s = 0; s < NS; s++) sets[s*SW +: SW] = fval(s, ncyc);
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not finish (act=%0d exp<150000)", wd);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [RW-1:0] d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    n0 = ncyc;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  function automatic bit mt(input logic [SW-1:0] v, input logic [SW-1:0] p, input logic [SW-1:0] m);
    return ((v & m) == (p & m));
  endfunction

  // cs_sel: written capture index; cs_eff: set expected to appear
  task automatic run(input int cs_sel, input int cs_eff, input int ts, input bit use_ext,
                     input logic [SW-1:0] pat, input logic [SW-1:0] msk,
                     input int pre, input string tag);
    int t;
    int last;
    int i;
    int guard;
    wr(3'd4, 16'h0002);
    wr(3'd0, RW'(pat));
    wr(3'd1, RW'(msk));
    wr(3'd2, RW'({use_ext, 4'(ts), 4'(cs_sel)}));
    wr(3'd3, RW'(pre));
    wr(3'd4, 16'h0001);
    chk(state == 2'd1, {tag, " R6 armed"}, state, 1);
    if (use_ext) begin
      t = pre + 2;
    end else begin
      t = -1;
      for (int k = 0; k < 2000 && t < 0; k++) begin
        if (k >= pre && mt(fval(ts, n0 + 1 + k), pat, msk) &&
            !mt(fval(ts, n0 + k), pat, msk)) t = k;
      end
    end
    guard = 0;
    while (!done && guard < 3000) begin
      if (use_ext && ncyc == n0 + 1 + t) ext_trig = 1'b1;
      if (use_ext && ncyc == n0 + 4 + t) ext_trig = 1'b0;
      @(negedge clk); #1;
      guard++;
    end
    ext_trig = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    chk(done == 1'b1 && state == 2'd3, {tag, " R7 R9 done held"}, state, 3);
    chk(trig_addr == AW'(t % DP), {tag, " R7 trig addr"}, trig_addr, t % DP);
    last = t + (DP - 1 - pre);
    for (int a = 0; a < DP; a++) begin
      rd_addr = AW'(a);
      @(negedge clk); #1;
      i = last - ((last - a) % DP);
      chk(rd_data == fval(cs_eff, n0 + 1 + i),
          $sformatf("%s R2 R5 R6 R11 addr %0d", tag, a), rd_data, fval(cs_eff, n0 + 1 + i));
    end
  endtask

  initial begin
    rst_n = 1'b0; ext_trig = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(state == 2'd0 && done == 1'b0, "R1 reset state", state, 0);
    chk(trig_addr == '0, "R1 reset trig addr", trig_addr, 0);
    chk(rd_data == '0, "R1 reset read data", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(state == 2'd0, "R1 idle after release", state, 0);

    // R3 R5: pattern trigger on another set, full mask, several pre counts
    for (int cs = 0; cs < NS; cs++) begin
      run(cs, cs, (cs + 1) % NS, 1'b0, 8'h5A, 8'hFF, 0, "R3 p0");
      run(cs, cs, (cs + 2) % NS, 1'b0, 8'hC3, 8'hFF, 5, "R3 p5");
      run(cs, cs, (cs + 3) % NS, 1'b0, 8'h11, 8'hFF, 15, "R3 p15");
    end
    // R3: partial mask, match lasts 16 cycles, only the rising edge fires
    run(1, 1, 2, 1'b0, 8'h30, 8'hF0, 4, "R3 masked");
    // R5: same set for trigger and capture
    run(2, 2, 2, 1'b0, 8'h77, 8'hFF, 2, "R5 same set");
    // R4: external trigger
    for (int cs = 0; cs < NS; cs++) run(cs, cs, 0, 1'b1, 8'h00, 8'h00, cs * 4, "R4 ext");
    // R2: out-of-range capture index selects set 0
    run(7, 0, 1, 1'b1, 8'h00, 8'h00, 3, "R2 range");

    // R9: re-arm straight from DONE
    wr(3'd4, 16'h0001);
    chk(state == 2'd1, "R9 rearm from done", state, 1);
    // R8 R4: external source, pattern matches often, stays armed
    wr(3'd4, 16'h0002);
    wr(3'd0, 16'h0010);
    wr(3'd1, 16'h00FF);
    wr(3'd2, 16'h0100);
    wr(3'd4, 16'h0001);
    repeat (600) @(negedge clk);
    #1;
    chk(state == 2'd1, "R8 R4 armed indefinitely", state, 1);
    // R10: empty command does not abort; config write does
    wr(3'd4, 16'h0000);
    chk(state == 2'd1, "R10 empty cmd no abort", state, 1);
    wr(3'd1, 16'h00FF);
    chk(state == 2'd0, "R10 cfg write aborts", state, 0);
    // R10: abort during CAPTURING
    wr(3'd3, 16'h0000);
    wr(3'd4, 16'h0001);
    ext_trig = 1'b1;
    @(negedge clk); #1;
    @(negedge clk); #1;
    chk(state == 2'd2, "R10 capturing", state, 2);
    wr(3'd0, 16'h0000);
    chk(state == 2'd0, "R10 abort in capture", state, 0);
    ext_trig = 1'b0;
    // R9: clear has priority over arm
    wr(3'd4, 16'h0003);
    chk(state == 2'd0, "R9 clear beats arm", state, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule